// File: doc/BRIEF.md
# Dual Latching Parallel Port

This block provides two 8-bit general-purpose parallel ports, called A and B, behind a small synchronous register bus. Each port has an output register, a direction register and an input view. A direction bit of 1 makes that pin an output. The pins are modelled without tristate: each port has a separate input vector, output vector and output-enable vector.

Each port also has a control-line input. When input capture is enabled for a port, the active edge of its control line freezes that port's pin levels in a capture register. The next read of the port data address returns the frozen value and then releases the capture, so later reads follow the live pins again. A shared auxiliary register turns capture on or off for each port and selects the active edge for each control line.

The two ports differ on read-back. Port B returns its output register bit for every output-configured bit. Port A always returns the pin-derived value, so a heavily loaded output can read back inverted. The bus has no back-pressure: a read strobe is always accepted, and its data appears on `rdata` one cycle later. `rdata` then holds until the next read.

Top module: `pport_pair`

## Requirements
- R1: After reset, both output registers, both direction registers and the auxiliary register are zero. Every output-enable is therefore low, and reads of these registers return 0.
- R2: A write to offset 1 (port A) or offset 0 (port B) stores all 8 bits in that port's output register, and the output vector shows it from the next cycle. A write to offset 3 (A) or offset 2 (B) sets the direction bits, and the output-enable vector follows them from the next cycle.
- R3: The direction registers at offsets 3 and 2 read back their stored value. The auxiliary register at offset 11 reads back its 4 stored bits, and the upper bits read 0.
- R4: When capture is disabled for a port, a data read of that port returns the live input pins on the bus side.
- R5: The auxiliary register bits are: bit 0 enables port A capture, bit 1 enables port B capture, bit 2 sets port A polarity and bit 3 sets port B polarity. When capture is enabled, an active control-line edge freezes the port's pins, and a later data read returns the frozen value even if the pins have changed since the edge.
- R6: After one data read of a captured value, the port is transparent again and returns live pins until the next active edge.
- R7: A polarity bit of 0 makes the falling edge of the control line active, and a polarity bit of 1 makes the rising edge active. The opposite edge captures nothing.
- R8: On a port B data read, each bit with direction 1 returns the output register bit whatever the pin level. Each bit with direction 0 returns the input view.
- R9: On a port A data read, every bit returns the input view, including bits configured as outputs.
- R10: If an active edge is seen in the same cycle as a data read of a captured port, that read returns the old capture. The new pin value is captured and is held for the following read.
- R11: The read data appears the cycle after the read strobe and holds while no read is strobed. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 4 | Register offset |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output register |
| pa_oe | output | 8 | Port A output enables (direction) |
| pa_ctl | input | 1 | Port A control edge line, asynchronous |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output register |
| pb_oe | output | 8 | Port B output enables (direction) |
| pb_ctl | input | 1 | Port B control edge line, asynchronous |

## Verification
A corrupted output or direction register shows directly on `pa_out`, `pa_oe`, `pb_out` or `pb_oe` in the cycle after the faulty write. A fault in the capture state is visible only through a data read. It appears on `rdata` one cycle after the strobe, and a capture that never releases shows up only on the second read after an edge. Edge faults appear no sooner than three cycles after the control line moves, because of the synchronizer. For that reason the stimulus holds the pins stable for that window, then changes them before reading.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int AUXW = 4;

  localparam logic [AW-1:0] OFS_PB_DATA = 4'd0;
  localparam logic [AW-1:0] OFS_PA_DATA = 4'd1;
  localparam logic [AW-1:0] OFS_PB_DIR  = 4'd2;
  localparam logic [AW-1:0] OFS_PA_DIR  = 4'd3;
  localparam logic [AW-1:0] OFS_AUX     = 4'd11;

  localparam int AUX_A_LE  = 0;
  localparam int AUX_B_LE  = 1;
  localparam int AUX_A_POL = 2;
  localparam int AUX_B_POL = 3;
endpackage

// File: rtl/pp_edge.sv
module pp_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ctl,
  input  logic pol,
  output logic hit
);
  localparam int SW = STAGES + 1;
  logic [SW-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SW-2:0], ctl};
  end

  // sh[STAGES-1] is the newest synchronized level, sh[STAGES] the previous one
  assign hit = pol ? ( sh[STAGES-1] & ~sh[STAGES])
                   : (~sh[STAGES-1] &  sh[STAGES]);
endmodule

// File: rtl/pp_port.sv
module pp_port #(
  parameter int DW = 8,
  parameter bit OUT_BITS_FROM_REG = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] pin_i,
  input  logic          ctl,
  input  logic          le,
  input  logic          pol,
  input  logic          wr_or,
  input  logic          wr_ddr,
  input  logic          rd_data,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] pin_o,
  output logic [DW-1:0] pin_oe,
  output logic [DW-1:0] rd_val
);
  logic          hit;
  logic          held;
  logic [DW-1:0] cap, or_q, ddr_q, in_view;

  pp_edge #(.STAGES(2)) u_edge (
    .clk(clk), .rst(rst), .ctl(ctl), .pol(pol), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      or_q  <= '0;
      ddr_q <= '0;
      cap   <= '0;
      held  <= 1'b0;
    end else begin
      if (wr_or)  or_q  <= wdata;
      if (wr_ddr) ddr_q <= wdata;
      if (!le) begin
        held <= 1'b0;
      end else if (hit) begin
        cap  <= pin_i;       // a new edge wins over a release by read
        held <= 1'b1;
      end else if (rd_data) begin
        held <= 1'b0;
      end
    end
  end

  assign in_view = (le && held) ? cap : pin_i;
  assign pin_o   = or_q;
  assign pin_oe  = ddr_q;

  generate
    if (OUT_BITS_FROM_REG) begin : g_reg_rb
      assign rd_val = (or_q & ddr_q) | (in_view & ~ddr_q);
    end else begin : g_pin_rb
      assign rd_val = in_view;
    end
  endgenerate
endmodule

// File: rtl/pport_pair.sv
module pport_pair
  import pp_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_oe,
  input  logic          pa_ctl,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_oe,
  input  logic          pb_ctl
);
  logic [AUXW-1:0] aux_q;
  logic [DW-1:0]   a_val, b_val, rmux;

  always_ff @(posedge clk) begin
    if (rst)                        aux_q <= '0;
    else if (wr && addr == OFS_AUX) aux_q <= wdata[AUXW-1:0];
  end

  pp_port #(.DW(DW), .OUT_BITS_FROM_REG(1'b0)) u_pa (
    .clk(clk), .rst(rst), .pin_i(pa_in), .ctl(pa_ctl),
    .le(aux_q[AUX_A_LE]), .pol(aux_q[AUX_A_POL]),
    .wr_or(wr && addr == OFS_PA_DATA), .wr_ddr(wr && addr == OFS_PA_DIR),
    .rd_data(rd && addr == OFS_PA_DATA), .wdata(wdata),
    .pin_o(pa_out), .pin_oe(pa_oe), .rd_val(a_val)
  );

  pp_port #(.DW(DW), .OUT_BITS_FROM_REG(1'b1)) u_pb (
    .clk(clk), .rst(rst), .pin_i(pb_in), .ctl(pb_ctl),
    .le(aux_q[AUX_B_LE]), .pol(aux_q[AUX_B_POL]),
    .wr_or(wr && addr == OFS_PB_DATA), .wr_ddr(wr && addr == OFS_PB_DIR),
    .rd_data(rd && addr == OFS_PB_DATA), .wdata(wdata),
    .pin_o(pb_out), .pin_oe(pb_oe), .rd_val(b_val)
  );

  always_comb begin
    rmux = '0;
    case (addr)
      OFS_PB_DATA: rmux = b_val;
      OFS_PA_DATA: rmux = a_val;
      OFS_PB_DIR:  rmux = pb_oe;
      OFS_PA_DIR:  rmux = pa_oe;
      OFS_AUX:     rmux = {{(DW-AUXW){1'b0}}, aux_q};
      default:     rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rmux;
  end
endmodule

// File: rtl/pp_chk.sv
module pp_chk
  import pp_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic [AW-1:0]   addr,
  input logic            wr,
  input logic            rd,
  input logic [DW-1:0]   wdata,
  input logic [DW-1:0]   rdata,
  input logic [DW-1:0]   pa_in,
  input logic [DW-1:0]   pa_out,
  input logic [DW-1:0]   pa_oe,
  input logic [DW-1:0]   pb_out,
  input logic [DW-1:0]   pb_oe,
  input logic [AUXW-1:0] aux_q
);
  AST_PA_OUT_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == OFS_PA_DATA) |=> pa_out == $past(wdata)); // R2
  AST_PA_DIR_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == OFS_PA_DIR) |=> pa_oe == $past(wdata)); // R2
  AST_PB_OUT_READBACK: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == OFS_PB_DATA) |=> ((rdata ^ $past(pb_out)) & $past(pb_oe)) == '0); // R8
  AST_PA_LIVE_READ: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == OFS_PA_DATA && !aux_q[AUX_A_LE]) |=> rdata == $past(pa_in)); // R4
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata)); // R11
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd && addr > OFS_PA_DIR && addr != OFS_AUX) |=> rdata == '0); // R11
endmodule

bind pport_pair pp_chk u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr(wr), .rd(rd), .wdata(wdata),
  .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
  .pb_out(pb_out), .pb_oe(pb_oe), .aux_q(aux_q)
);

// File: tb/sim_pport_pair.sv
`timescale 1ns/1ps
module sim_pport_pair;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] pa_in = '0, pa_out, pa_oe;
  logic [7:0] pb_in = '0, pb_out, pb_oe;
  logic       pa_ctl = 1'b0, pb_ctl = 1'b0;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  pport_pair u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr(wr), .rd(rd), .wdata(wdata),
    .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe), .pa_ctl(pa_ctl),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pb_ctl(pb_ctl)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [3:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); @(negedge clk);
    wr = 1'b0;
  endtask

  // driver: issue a read and queue the value it must return
  task automatic rd_reg(logic [3:0] a, logic [7:0] exp, string tag);
    addr = a; rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: a read seen at an edge is compared at the following negedge
  initial begin
    forever begin
      @(posedge clk);
      if (rd) begin
        @(negedge clk);
        if (exp_q.size() > 0) chk(tag_q.pop_front(), rdata, exp_q.pop_front());
        else chk("R11 unexpected read", rdata, 8'hxx);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    chk("R1 pa_oe", pa_oe, 8'h00);
    chk("R1 pb_oe", pb_oe, 8'h00);
    chk("R1 pa_out", pa_out, 8'h00);
    rd_reg(4'd11, 8'h00, "R1 aux");
    rd_reg(4'd2, 8'h00, "R1 ddrb");

    wr_reg(4'd1, 8'hA5);
    wr_reg(4'd3, 8'h0F);
    chk("R2 pa_out", pa_out, 8'hA5);
    chk("R2 pa_oe", pa_oe, 8'h0F);
    rd_reg(4'd3, 8'h0F, "R3 ddra");

    pa_in = 8'h3C;
    rd_reg(4'd1, 8'h3C, "R9 outputs read pin");
    pa_in = 8'h77;
    rd_reg(4'd1, 8'h77, "R4 live A");

    wr_reg(4'd0, 8'h5A);
    wr_reg(4'd2, 8'hF0);
    chk("R2 pb_out", pb_out, 8'h5A);
    chk("R2 pb_oe", pb_oe, 8'hF0);
    pb_in = 8'h0F;
    rd_reg(4'd0, 8'h5F, "R8 B mix");
    pb_in = 8'hA3;
    rd_reg(4'd0, 8'h53, "R8 B pin ignored");

    wr_reg(4'd11, 8'hFF);
    rd_reg(4'd11, 8'h0F, "R3 aux width");
    wr_reg(4'd11, 8'h03);     // capture on both, falling edges

    pa_in = 8'h10; pa_ctl = 1'b1; idle(4);
    pa_in = 8'h20;
    rd_reg(4'd1, 8'h20, "R7 rising ignored");

    pa_in = 8'h11; pa_ctl = 1'b0; idle(4);
    pa_in = 8'h22;
    rd_reg(4'd1, 8'h11, "R5 captured A");
    rd_reg(4'd1, 8'h22, "R6 transparent A");
    pa_in = 8'h33;
    rd_reg(4'd1, 8'h33, "R6 follows pins");

    wr_reg(4'd11, 8'h07);     // port A rising
    pa_in = 8'h44; pa_ctl = 1'b1; idle(4);
    pa_in = 8'h55;
    rd_reg(4'd1, 8'h44, "R7 rising capture");
    rd_reg(4'd1, 8'h55, "R6 after rising");

    pb_ctl = 1'b1; idle(4);
    pb_in = 8'h06; pb_ctl = 1'b0; idle(4);
    pb_in = 8'h09;
    rd_reg(4'd0, 8'h56, "R5 captured B");
    rd_reg(4'd0, 8'h59, "R6 transparent B");

    pa_ctl = 1'b0; idle(4);
    pa_in = 8'h61; pa_ctl = 1'b1; idle(4);
    pa_in = 8'h62; pa_ctl = 1'b0; idle(4);
    pa_ctl = 1'b1; idle(2);   // edge is seen at the third edge, with the read
    rd_reg(4'd1, 8'h61, "R10 old value");
    pa_in = 8'h63;
    rd_reg(4'd1, 8'h62, "R10 new capture");
    rd_reg(4'd1, 8'h63, "R10 released");

    rd_reg(4'd5, 8'h00, "R11 unmapped");
    idle(3);
    chk("R11 hold", rdata, 8'h00);
    rd_reg(4'd3, 8'h0F, "R11 latency");
    idle(3);
    chk("R11 hold dir", rdata, 8'h0F);

    idle(2);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule